// File: doc/BRIEF.md
# Sticky Fault Status Register

This block gathers fault detections from a sensor front end and keeps them in two 8-bit sticky registers, an upper register (`FAULT1`) and a lower register (`FAULT0`). Each bit sets when its condition is seen. It stays set until the bus master reads the pair at the fault address. If the condition is still present when the read clears the bit, the bit stays set, and it holds until a later read finds the condition gone.

The raw inputs have three kinds of conditioning:

- **Regulator voltage.** It arrives as a millivolt sample with a valid strobe. An over-limit or under-limit excursion is recognised only after a run of consecutive qualifying samples. This run plays the part of a low-pass filter.
- **Quadrature magnitude.** It is compared against a fixed limit.
- **Other detectors.** They are taken as levels.

Next to the read port, the block gives a compact per-response view for every sensor data response. This is a fault byte in which the amplitude failure is merged into the self-test position, plus a 2-bit status code. A phase-locked loop failure drives that code to the invalid value.

Top module: `sensor_fault_reg`

## Requirements
- R1: On synchronous reset every fault bit clears. A read of the fault address then returns 16'h0000, the response byte is 8'h00 and the status code is 2'b01.
- R2: A fault bit sets on the clock edge where its condition is active. It stays set after the condition goes away, until a read at the fault address.
- R3: A read with `rd_addr` equal to 0x0A returns {FAULT1, FAULT0} in the same cycle, and each bit whose condition is inactive is 0 from the next cycle. A read at any other address returns 16'h0000 and changes no bit.
- R4: When a bit's condition is active in the cycle it is read, the read returns its old value and the bit remains set after the read.
- R5: Over-voltage (FAULT1 bit 5) sets only after RUN_LEN consecutive valid samples above OV_MV. Under-voltage (FAULT1 bit 4) sets only after RUN_LEN consecutive valid samples below UV_MV. A sample equal to the limit breaks the run.
- R6: The power bit (FAULT0 bit 3) sets on the same edge as an over-voltage or under-voltage bit.
- R7: The quadrature bit (FAULT0 bit 6) sets when `quad_mag` is greater than Q_LIMIT (4096). A value equal to 4096 does not set it.
- R8: `resp_flt` equals FAULT0, except that bit 2 is the OR of the self-test bit (FAULT0 bit 2) and the amplitude bit (FAULT1 bit 6). The amplitude bit appears in FAULT1 bit 6 on a read.
- R9: `resp_st` is 2'b00 while the PLL bit (FAULT0 bit 7) is set. Otherwise it is 2'b10 when `resp_flt` is nonzero, and 2'b01 when it is zero.
- R10: The fail bit (FAULT1 bit 7) sets on the edge after any cycle in which `resp_st` is 2'b00.
- R11: Bit map: FAULT1 = {fail, amplitude, over-voltage, under-voltage, 4'b0}. FAULT0 = {PLL, quadrature, memory checksum, power-on init, power, self-test, check, 1'b0}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| amp_det | input | 1 | Resonator amplitude failure level |
| cst_det | input | 1 | Continuous self-test failure level |
| pll_det | input | 1 | PLL lock failure level |
| nvm_det | input | 1 | Memory checksum failure level |
| por_det | input | 1 | Power-on initialisation failure level |
| chk_det | input | 1 | Forced fault (check) request level |
| vreg_vld | input | 1 | Regulator voltage sample valid |
| vreg_mv | input | MV_W | Regulator voltage sample, unsigned millivolts |
| quad_mag | input | QW | Instantaneous quadrature magnitude, LSB |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | AW | Register read address |
| rd_data | output | 16 | {FAULT1, FAULT0} on a fault-address read, else 0 |
| resp_flt | output | 8 | Per-response fault byte |
| resp_st | output | 2 | Per-response status code |

## Verification
The bench targets these corner cases:

- **Read colliding with a live fault.** A design where clear beats set would drop the bit for one cycle and lose a fault the master never saw.
- **Voltage runs broken by a sample exactly at the limit, and a quadrature value exactly at 4096.** An off-by-one comparison or a run counter that fails to restart would report a fault too early.
- **Interaction of PLL, status and fail.** The fail bit must trail the invalid status by one edge and survive the read that clears the PLL bit. A design that derived fail from the live input, or cleared it along with the PLL bit, would lose it.
- **Amplitude merge.** This shows up only in the response byte, never in the stored self-test bit.

// File: rtl/sfr_pkg.sv
package sfr_pkg;

  // FAULT1 bit positions
  localparam int F1_FAIL = 7;
  localparam int F1_AMP  = 6;
  localparam int F1_OV   = 5;
  localparam int F1_UV   = 4;

  // FAULT0 bit positions (also the per-response byte layout)
  localparam int F0_PLL  = 7;
  localparam int F0_Q    = 6;
  localparam int F0_NVM  = 5;
  localparam int F0_POR  = 4;
  localparam int F0_PWR  = 3;
  localparam int F0_CST  = 2;
  localparam int F0_CHK  = 1;

  typedef enum logic [1:0] {
    ST_INVALID = 2'b00,
    ST_OK      = 2'b01,
    ST_FAULT   = 2'b10
  } resp_st_e;

  // Voltage excursion test: above or below the limit, equality never trips
  function automatic logic volt_trips(input logic [31:0] mv,
                                      input logic [31:0] limit,
                                      input logic        above);
    return above ? (mv > limit) : (mv < limit);
  endfunction

  // Response byte: amplitude failure folded into the self-test position
  function automatic logic [7:0] merge_resp(input logic [7:0] f0,
                                            input logic       amp);
    logic [7:0] r;
    r         = f0;
    r[F0_CST] = f0[F0_CST] | amp;
    return r;
  endfunction

  // Status code priority: PLL first, then any reported fault
  function automatic resp_st_e status_of(input logic       pll,
                                         input logic [7:0] resp);
    if (pll)              return ST_INVALID;
    else if (resp != 8'h00) return ST_FAULT;
    else                  return ST_OK;
  endfunction

endpackage

// File: rtl/sfr_volt_filter.sv
module sfr_volt_filter #(
  parameter int MV_W    = 16,
  parameter int LIMIT   = 3300,
  parameter bit ABOVE   = 1'b1,
  parameter int RUN_LEN = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            smp_vld,
  input  logic [MV_W-1:0] smp_mv,
  output logic            tripped
);
  import sfr_pkg::*;

  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] FULL = CW'(RUN_LEN);

  logic [CW-1:0] run_cnt;
  logic          qual;

  assign qual = volt_trips(32'(smp_mv), 32'(LIMIT), ABOVE);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt <= '0;
    end else if (smp_vld) begin
      if (!qual)               run_cnt <= '0;
      else if (run_cnt != FULL) run_cnt <= run_cnt + 1'b1;
    end
  end

  assign tripped = (run_cnt == FULL);

endmodule

// File: rtl/sfr_sticky_bank.sv
module sfr_sticky_bank #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic b;
    always_ff @(posedge clk) begin
      if (rst) b <= 1'b0;
      else     b <= set_i[i] | (b & ~clr_i);
    end
    assign q_o[i] = b;
  end
endmodule

// File: rtl/sfr_resp_view.sv
module sfr_resp_view (
  input  logic [7:0] f1,
  input  logic [7:0] f0,
  output logic [7:0] resp_flt,
  output logic [1:0] resp_st
);
  import sfr_pkg::*;

  logic [7:0] merged;
  assign merged   = merge_resp(f0, f1[F1_AMP]);
  assign resp_flt = merged;
  assign resp_st  = status_of(f0[F0_PLL], merged);
endmodule

// File: rtl/sensor_fault_reg.sv
module sensor_fault_reg #(
  parameter int          MV_W       = 16,
  parameter int          QW         = 16,
  parameter int          AW         = 9,
  parameter logic [8:0]  FAULT_ADDR = 9'h00A,
  parameter int          OV_MV      = 3300,
  parameter int          UV_MV      = 2770,
  parameter int          RUN_LEN    = 8,
  parameter int          Q_LIMIT    = 4096
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            amp_det,
  input  logic            cst_det,
  input  logic            pll_det,
  input  logic            nvm_det,
  input  logic            por_det,
  input  logic            chk_det,
  input  logic            vreg_vld,
  input  logic [MV_W-1:0] vreg_mv,
  input  logic [QW-1:0]   quad_mag,
  input  logic            rd_en,
  input  logic [AW-1:0]   rd_addr,
  output logic [15:0]     rd_data,
  output logic [7:0]      resp_flt,
  output logic [1:0]      resp_st
);
  import sfr_pkg::*;

  // named internal events
  logic       read_hit;
  logic       ov_trip;
  logic       uv_trip;
  logic       q_trip;
  logic       pwr_trip;
  logic       invalid_st;
  logic [7:0] set1;
  logic [7:0] set0;
  logic [7:0] flt1;
  logic [7:0] flt0;

  assign read_hit = rd_en && (rd_addr == AW'(FAULT_ADDR));
  assign q_trip   = (quad_mag > QW'(Q_LIMIT));
  assign pwr_trip = ov_trip | uv_trip;

  sfr_volt_filter #(
    .MV_W(MV_W), .LIMIT(OV_MV), .ABOVE(1'b1), .RUN_LEN(RUN_LEN)
  ) u_ov (
    .clk(clk), .rst(rst), .smp_vld(vreg_vld), .smp_mv(vreg_mv), .tripped(ov_trip)
  );

  sfr_volt_filter #(
    .MV_W(MV_W), .LIMIT(UV_MV), .ABOVE(1'b0), .RUN_LEN(RUN_LEN)
  ) u_uv (
    .clk(clk), .rst(rst), .smp_vld(vreg_vld), .smp_mv(vreg_mv), .tripped(uv_trip)
  );

  assign invalid_st = (resp_st == ST_INVALID);

  always_comb begin
    set1          = '0;
    set1[F1_FAIL] = invalid_st;
    set1[F1_AMP]  = amp_det;
    set1[F1_OV]   = ov_trip;
    set1[F1_UV]   = uv_trip;
    set0          = '0;
    set0[F0_PLL]  = pll_det;
    set0[F0_Q]    = q_trip;
    set0[F0_NVM]  = nvm_det;
    set0[F0_POR]  = por_det;
    set0[F0_PWR]  = pwr_trip;
    set0[F0_CST]  = cst_det;
    set0[F0_CHK]  = chk_det;
  end

  sfr_sticky_bank #(.W(8)) u_bank1 (
    .clk(clk), .rst(rst), .set_i(set1), .clr_i(read_hit), .q_o(flt1)
  );

  sfr_sticky_bank #(.W(8)) u_bank0 (
    .clk(clk), .rst(rst), .set_i(set0), .clr_i(read_hit), .q_o(flt0)
  );

  sfr_resp_view u_view (
    .f1(flt1), .f0(flt0), .resp_flt(resp_flt), .resp_st(resp_st)
  );

  assign rd_data = read_hit ? {flt1, flt0} : 16'h0000;

endmodule

// File: rtl/sfr_checker.sv
module sfr_checker #(
  parameter int QW      = 16,
  parameter int Q_LIMIT = 4096
) (
  input logic          clk,
  input logic          rst,
  input logic          read_hit,
  input logic          ov_trip,
  input logic          uv_trip,
  input logic [QW-1:0] quad_mag,
  input logic [7:0]    set1,
  input logic [7:0]    set0,
  input logic [7:0]    flt1,
  input logic [7:0]    flt0,
  input logic [15:0]   rd_data,
  input logic [7:0]    resp_flt,
  input logic [1:0]    resp_st
);
  logic [15:0] fv;
  logic [15:0] sv;
  assign fv = {flt1, flt0};
  assign sv = {set1, set0};

  p_sticky_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (!read_hit) |=> ((fv & $past(fv)) == $past(fv)));

  p_idle_read_r3: assert property (@(posedge clk) disable iff (rst)
    (!read_hit) |-> (rd_data == 16'h0000));

  p_set_wins_r4: assert property (@(posedge clk) disable iff (rst)
    (sv != 16'h0000) |=> ((fv & $past(sv)) == $past(sv)));

  p_pwr_follows_r6: assert property (@(posedge clk) disable iff (rst)
    (ov_trip || uv_trip) |=> flt0[3]);

  p_quad_limit_r7: assert property (@(posedge clk) disable iff (rst)
    (quad_mag > QW'(Q_LIMIT)) |=> flt0[6]);

  p_amp_merge_r8: assert property (@(posedge clk) disable iff (rst)
    flt1[6] |-> resp_flt[2]);

  p_pll_status_r9: assert property (@(posedge clk) disable iff (rst)
    flt0[7] |-> (resp_st == 2'b00));

  p_status_legal_r9: assert property (@(posedge clk) disable iff (rst)
    resp_st != 2'b11);

  p_fail_trails_r10: assert property (@(posedge clk) disable iff (rst)
    (resp_st == 2'b00) |=> flt1[7]);

  p_spare_zero_r11: assert property (@(posedge clk) disable iff (rst)
    (flt1[3:0] == 4'h0) && (flt0[0] == 1'b0));
endmodule

bind sensor_fault_reg sfr_checker #(.QW(QW), .Q_LIMIT(Q_LIMIT)) u_chk (
  .clk(clk), .rst(rst), .read_hit(read_hit), .ov_trip(ov_trip),
  .uv_trip(uv_trip), .quad_mag(quad_mag), .set1(set1), .set0(set0),
  .flt1(flt1), .flt0(flt0), .rd_data(rd_data), .resp_flt(resp_flt),
  .resp_st(resp_st)
);

// File: tb/sensor_fault_reg_tb.sv
module sensor_fault_reg_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        amp_det = 0, cst_det = 0, pll_det = 0, nvm_det = 0, por_det = 0, chk_det = 0;
  logic        vreg_vld = 0;
  logic [15:0] vreg_mv = 16'd3000;
  logic [15:0] quad_mag = '0;
  logic        rd_en = 0;
  logic [8:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [7:0]  resp_flt;
  logic [1:0]  resp_st;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  sensor_fault_reg u_dut (
    .clk(clk), .rst(rst), .amp_det(amp_det), .cst_det(cst_det), .pll_det(pll_det),
    .nvm_det(nvm_det), .por_det(por_det), .chk_det(chk_det), .vreg_vld(vreg_vld),
    .vreg_mv(vreg_mv), .quad_mag(quad_mag), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .resp_flt(resp_flt), .resp_st(resp_st)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit m_fail, m_amp, m_ov, m_uv, m_pll, m_q, m_nvm, m_por, m_pwr, m_cst, m_chk;
  int ov_run = 0, uv_run = 0;

  function automatic logic [7:0] m_resp();
    return {m_pll, m_q, m_nvm, m_por, m_pwr, m_cst | m_amp, m_chk, 1'b0};
  endfunction

  function automatic logic [1:0] m_stat();
    if (m_pll) return 2'b00;
    if (m_resp() != 0) return 2'b10;
    return 2'b01;
  endfunction

  function automatic logic [15:0] m_rd();
    if (!(rd_en && rd_addr == 9'h00A)) return 16'h0;
    return {m_fail, m_amp, m_ov, m_uv, 4'h0, m_resp() & ~8'h04 | {5'b0, m_cst, 2'b0}};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      {m_fail, m_amp, m_ov, m_uv, m_pll, m_q, m_nvm, m_por, m_pwr, m_cst, m_chk} = '0;
      ov_run = 0; uv_run = 0;
    end else begin
      bit hit, ovt, uvt, inval;
      hit   = rd_en && (rd_addr == 9'h00A);
      ovt   = (ov_run >= 8);
      uvt   = (uv_run >= 8);
      inval = (m_stat() == 2'b00);
      m_fail = inval            || (m_fail && !hit);
      m_amp  = amp_det          || (m_amp  && !hit);
      m_ov   = ovt              || (m_ov   && !hit);
      m_uv   = uvt              || (m_uv   && !hit);
      m_pll  = pll_det          || (m_pll  && !hit);
      m_q    = (quad_mag > 4096) || (m_q   && !hit);
      m_nvm  = nvm_det          || (m_nvm  && !hit);
      m_por  = por_det          || (m_por  && !hit);
      m_pwr  = ovt || uvt       || (m_pwr  && !hit);
      m_cst  = cst_det          || (m_cst  && !hit);
      m_chk  = chk_det          || (m_chk  && !hit);
      if (vreg_vld) begin
        ov_run = (vreg_mv > 3300) ? ((ov_run < 8) ? ov_run + 1 : 8) : 0;
        uv_run = (vreg_mv < 2770) ? ((uv_run < 8) ? uv_run + 1 : 8) : 0;
      end
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      check("R2/R3 model rd_data", rd_data, m_rd());
      check("R8 model resp_flt", {8'h0, resp_flt}, {8'h0, m_resp()});
      check("R9 model resp_st", {14'h0, resp_st}, {14'h0, m_stat()});
    end
  end

  // ---------------- directed stimulus ----------------
  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic read_at(input logic [8:0] a, input logic [15:0] exp, input string tag);
    rd_en = 1; rd_addr = a; #1;
    check(tag, rd_data, exp);
    tick();
    rd_en = 0;
  endtask

  initial begin
    #(200000 * 10);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    vreg_vld = 1;
    repeat (3) tick();
    rst = 0;
    // R1 reset state
    check("R1 status after reset", {14'h0, resp_st}, 16'h0001);
    check("R1 resp after reset", {8'h0, resp_flt}, 16'h0000);
    read_at(9'h00A, 16'h0000, "R1 read after reset");

    // R2 sticky, R11 memory bit at FAULT0 bit 5
    nvm_det = 1; tick(); nvm_det = 0; tick(); tick();
    check("R2 sticky nvm", {8'h0, resp_flt}, 16'h0020);
    check("R9 fault status", {14'h0, resp_st}, 16'h0002);
    read_at(9'h00B, 16'h0000, "R3 other address reads zero");
    check("R3 other address no clear", {8'h0, resp_flt}, 16'h0020);
    read_at(9'h00A, 16'h0020, "R11 nvm map");
    check("R3 cleared after read", {8'h0, resp_flt}, 16'h0000);
    check("R9 ok status", {14'h0, resp_st}, 16'h0001);

    // R4 set wins over read
    chk_det = 1; tick();
    read_at(9'h00A, 16'h0002, "R4 read live chk");
    check("R4 chk kept after read", {8'h0, resp_flt}, 16'h0002);
    chk_det = 0;
    read_at(9'h00A, 16'h0002, "R4 second read");
    check("R2 chk cleared", {8'h0, resp_flt}, 16'h0000);

    // R7 quadrature boundary
    quad_mag = 16'd4096; tick(); tick();
    check("R7 at limit no fault", {8'h0, resp_flt}, 16'h0000);
    quad_mag = 16'd4097; tick(); quad_mag = 0;
    check("R7 above limit", {8'h0, resp_flt}, 16'h0040);
    read_at(9'h00A, 16'h0040, "R7 read q");

    // R8 amplitude merge
    amp_det = 1; tick(); amp_det = 0;
    check("R8 amp in cst position", {8'h0, resp_flt}, 16'h0004);
    read_at(9'h00A, 16'h4000, "R8 amp stored in FAULT1");

    // R5 over-voltage run, broken by a sample at the limit
    vreg_mv = 16'd3400; repeat (7) tick();
    vreg_mv = 16'd3300; tick();
    vreg_mv = 16'd3400; repeat (7) tick(); tick();
    check("R5 broken run no fault", {8'h0, resp_flt}, 16'h0000);
    repeat (2) tick();
    check("R6 pwr with ov", {8'h0, resp_flt}, 16'h0008);
    vreg_mv = 16'd3000; repeat (2) tick();
    read_at(9'h00A, 16'h2008, "R5 ov bit map");
    check("R5 ov cleared", {8'h0, resp_flt}, 16'h0000);

    // R5 under-voltage
    vreg_mv = 16'd2700; repeat (9) tick();
    vreg_mv = 16'd3000; repeat (2) tick();
    read_at(9'h00A, 16'h1008, "R5 uv and R6 pwr");

    // R9 / R10 PLL, status and fail
    pll_det = 1; tick(); pll_det = 0;
    check("R9 pll invalid status", {14'h0, resp_st}, 16'h0000);
    tick();
    read_at(9'h00A, 16'h8080, "R10 fail follows invalid");
    check("R9 status ok after pll clear", {14'h0, resp_st}, 16'h0001);
    read_at(9'h00A, 16'h8000, "R10 fail survives read");
    read_at(9'h00A, 16'h0000, "R10 fail cleared");

    // R1 reset mid-run clears everything
    por_det = 1; cst_det = 1; tick(); tick();
    rst = 1; tick(); por_det = 0; cst_det = 0; tick(); rst = 0;
    check("R1 reset clears resp", {8'h0, resp_flt}, 16'h0000);
    read_at(9'h00A, 16'h0000, "R1 reset clears regs");

    repeat (3) tick();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule